// File: doc/BRIEF.md
# Bus Hold Handshake Controller

This block hands a processor's local bus over to an external master and takes it back. An external master raises an asynchronous hold request. The block passes that request through a synchronizer. It then waits until no bus cycles are outstanding and no locked read-modify-write sequence is active. Once both are clear, it raises the hold acknowledge and the float enable in the same clock. The float enable tells the bus interface to tri-state its outputs.

The bus stays granted away for as long as the synchronized request stays high. When the request is withdrawn, acknowledge and float enable drop together. In that same clock a strobe starts the pending bus cycle, if one is waiting. Throughout, the bus request output mirrors the internal demand, including while the bus is granted. An external arbiter can therefore grant the bus back on demand only.

All pins are plain control levels or strobes. There is no data stream and no valid/ready handshake. The block is one clock domain with a synchronous, active-high reset. The only asynchronous input is the hold request.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While reset is high and no synchronized hold request is present, hold_ack, float_en, start_pend and bus_req are all 0.
- R2: hold_req passes through SYNC_STAGES flops (default 2). With no outstanding cycles and no lock, hold_ack rises on the clock edge after the synchronized request is seen. With the default this is the third rising edge after hold_req goes high.
- R3: hold_ack stays 0 while outst_cnt is nonzero. It rises on the edge after outst_cnt reads zero, provided the synchronized request is still present.
- R4: float_en equals hold_ack in every cycle. Both come from registers.
- R5: hold_ack stays 0 while lock_act is 1. It rises on the edge after lock_act reads 0, provided the synchronized request is still present.
- R6: Once high, hold_ack stays high, whatever outst_cnt and lock_act do, until the synchronized request is low. It falls on the edge where the synchronized request is first seen low.
- R7: start_pend is a one-cycle pulse, in the cycle where hold_ack falls. It is 1 only if pend_req was 1 at that edge; otherwise it stays 0.
- R8: bus_req equals pend_req delayed by one clock, whatever the state of hold_ack.
- R9: A hold request is recognized during reset. While reset is high, hold_ack follows the synchronized request whenever outst_cnt is zero and lock_act is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold_req | input | 1 | Asynchronous bus hold request from an external master |
| pend_req | input | 1 | An internal memory request is pending |
| outst_cnt | input | OUTST_W | Number of bus cycles still outstanding |
| lock_act | input | 1 | A locked bus sequence is in progress |
| hold_ack | output | 1 | Bus granted to the external master |
| bus_req | output | 1 | Internal demand for the bus, registered |
| float_en | output | 1 | Tri-state the bus interface outputs |
| start_pend | output | 1 | Start the pending bus cycle (one-cycle strobe) |

## Verification
The embedded assertions watch several properties on every clock:
- float_en tracks hold_ack.
- An acknowledge never rises while cycles are outstanding, while a lock is active, or without a synchronized request.
- A granted bus is never withdrawn while the request persists.
- start_pend fires only on a falling acknowledge.

The bench's scenarios are needed for the timing claims, which the assertions cannot establish:
- the exact synchronizer latency;
- the acknowledge following one edge after a drain or an unlock;
- recognition of a request during reset;
- the strobe depending on whether a request was pending at release.

A behavioural model compared every cycle covers the registered bus request across grants.

// File: rtl/bh_pkg.sv
package bh_pkg;
  typedef enum logic {
    BUS_OWNED = 1'b0,
    BUS_LENT  = 1'b1
  } bus_own_e;
endpackage

// File: rtl/bh_sync.sv
module bh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  // No reset: the request must be seen even while reset is held.
  always_ff @(posedge clk) chain[0] <= d_async;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) chain[i] <= chain[i-1];
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/bh_grant_fsm.sv
module bh_grant_fsm
  import bh_pkg::*;
#(
  parameter int OUTST_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold_s,
  input  logic               pend_req,
  input  logic [OUTST_W-1:0] outst_cnt,
  input  logic               lock_act,
  output logic               hold_ack,
  output logic               float_en,
  output logic               start_pend,
  output logic               bus_req
);
  bus_own_e state_q, state_d;
  logic     quiet;
  logic     release_now;

  // The bus may be handed over only when no cycle is in flight and no lock is held.
  assign quiet       = (outst_cnt == '0) && !lock_act;
  assign release_now = (state_q == BUS_LENT) && !hold_s;

  always_comb begin
    state_d = state_q;
    if (rst) begin
      state_d = (hold_s && quiet) ? BUS_LENT : BUS_OWNED;
    end else begin
      unique case (state_q)
        BUS_OWNED: if (hold_s && quiet) state_d = BUS_LENT;
        BUS_LENT:  if (!hold_s)         state_d = BUS_OWNED;
        default:   state_d = BUS_OWNED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state_q    <= state_d;
    hold_ack   <= (state_d == BUS_LENT);
    float_en   <= (state_d == BUS_LENT);
    start_pend <= !rst && release_now && pend_req;
    bus_req    <= !rst && pend_req;
  end

  assert_float_tracks_ack_R4: assert property (@(posedge clk) disable iff (rst)
    float_en == hold_ack);

  assert_no_ack_while_busy_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(outst_cnt) == '0);

  assert_no_ack_while_locked_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> !$past(lock_act));

  assert_ack_needs_request_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(hold_s));

  assert_ack_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && hold_s) |=> hold_ack);

  assert_strobe_on_release_R7: assert property (@(posedge clk) disable iff (rst)
    start_pend |-> $fell(hold_ack));
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int OUTST_W     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold_req,
  input  logic               pend_req,
  input  logic [OUTST_W-1:0] outst_cnt,
  input  logic               lock_act,
  output logic               hold_ack,
  output logic               bus_req,
  output logic               float_en,
  output logic               start_pend
);
  logic hold_s;

  bh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .d_async (hold_req),
    .q_sync  (hold_s)
  );

  bh_grant_fsm #(.OUTST_W(OUTST_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .hold_s     (hold_s),
    .pend_req   (pend_req),
    .outst_cnt  (outst_cnt),
    .lock_act   (lock_act),
    .hold_ack   (hold_ack),
    .float_en   (float_en),
    .start_pend (start_pend),
    .bus_req    (bus_req)
  );
endmodule

// File: tb/bus_hold_ctrl_tb.sv
module bus_hold_ctrl_tb;
  localparam int NS = 2;
  localparam int OW = 2;

  logic clk = 0;
  logic rst = 1;
  logic hold_req = 0;
  logic pend_req = 0;
  logic [OW-1:0] outst_cnt = '0;
  logic lock_act = 0;
  logic hold_ack, bus_req, float_en, start_pend;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference model state
  bit e_ack = 0, e_start = 0, e_breq = 0;
  bit syncq[$];

  always #10 clk = ~clk;

  bus_hold_ctrl #(.SYNC_STAGES(NS), .OUTST_W(OW)) u_dut (
    .clk(clk), .rst(rst), .hold_req(hold_req), .pend_req(pend_req),
    .outst_cnt(outst_cnt), .lock_act(lock_act), .hold_ack(hold_ack),
    .bus_req(bus_req), .float_en(float_en), .start_pend(start_pend)
  );

  initial for (int i = 0; i < NS; i++) syncq.push_back(1'b0);

  // Behavioural model: request seen NS edges late; grant when quiet.
  always @(posedge clk) begin
    bit hs, qt;
    hs = syncq[$];
    qt = (outst_cnt == 0) && !lock_act;
    if (rst) begin
      e_ack = hs && qt; e_start = 0; e_breq = 0;
    end else begin
      e_breq = pend_req;
      if (!e_ack) begin
        e_ack = hs && qt; e_start = 0;
      end else if (!hs) begin
        e_ack = 0; e_start = pend_req;
      end else e_start = 0;
    end
    syncq.push_front(hold_req);
    void'(syncq.pop_back());
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge.
  always @(negedge clk) if (!rst && !done) begin
    chk(hold_ack == e_ack, "R2 hold_ack vs model", hold_ack, e_ack);
    chk(float_en == hold_ack, "R4 float_en vs hold_ack", float_en, hold_ack);
    chk(bus_req == e_breq, "R8 bus_req vs model", bus_req, e_breq);
    chk(start_pend == e_start, "R7 start_pend vs model", start_pend, e_start);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset with no request
    step(4);
    chk(hold_ack == 0 && float_en == 0 && start_pend == 0 && bus_req == 0,
        "R1 reset outputs", {hold_ack, float_en, start_pend, bus_req}, 0);
    rst = 0;
    step(2);

    // R2: synchronizer latency, idle bus
    hold_req = 1;
    step(2);
    chk(hold_ack == 0, "R2 ack before latency", hold_ack, 0);
    step(1);
    chk(hold_ack == 1, "R2 ack after latency", hold_ack, 1);
    chk(float_en == 1, "R4 float with ack", float_en, 1);
    // R8: demand visible while granted
    pend_req = 1;
    step(1);
    chk(bus_req == 1, "R8 bus_req during grant", bus_req, 1);
    // R6: lock/outstanding do not revoke grant
    lock_act = 1; outst_cnt = 2;
    step(3);
    chk(hold_ack == 1, "R6 ack kept", hold_ack, 1);
    lock_act = 0; outst_cnt = 0;
    // R6/R7: release with pending request
    hold_req = 0;
    step(2);
    chk(hold_ack == 1, "R6 ack before sync fall", hold_ack, 1);
    step(1);
    chk(hold_ack == 0, "R6 ack dropped", hold_ack, 0);
    chk(start_pend == 1, "R7 strobe with pending", start_pend, 1);
    step(1);
    chk(start_pend == 0, "R7 strobe one cycle", start_pend, 0);

    // R5: lock withholds ack
    lock_act = 1; hold_req = 1;
    step(6);
    chk(hold_ack == 0, "R5 ack withheld under lock", hold_ack, 0);
    lock_act = 0;
    step(1);
    chk(hold_ack == 1, "R5 ack after unlock", hold_ack, 1);
    // R7: release with no pending request
    pend_req = 0; hold_req = 0;
    step(3);
    chk(hold_ack == 0, "R7 ack dropped", hold_ack, 0);
    chk(start_pend == 0, "R7 no strobe without pending", start_pend, 1'b0);
    step(2);

    // R3: outstanding cycles delay ack
    outst_cnt = 3; hold_req = 1;
    step(5);
    chk(hold_ack == 0, "R3 ack withheld while outstanding", hold_ack, 0);
    outst_cnt = 1;
    step(2);
    chk(hold_ack == 0, "R3 still outstanding", hold_ack, 0);
    outst_cnt = 0;
    step(1);
    chk(hold_ack == 1, "R3 ack after drain", hold_ack, 1);
    hold_req = 0;
    step(4);

    // R9: request recognized during reset
    rst = 1; hold_req = 1; pend_req = 1;
    step(4);
    chk(hold_ack == 1, "R9 ack during reset", hold_ack, 1);
    chk(float_en == 1, "R9 float during reset", float_en, 1);
    chk(bus_req == 0, "R1 bus_req in reset", bus_req, 0);
    rst = 0;
    step(2);
    chk(hold_ack == 1, "R9 ack kept after reset", hold_ack, 1);
    hold_req = 0;
    step(4);

    // Mixed pattern, compared per cycle by the model
    for (int i = 0; i < 200; i++) begin
      hold_req  = ((i / 7) % 2) == 1;
      pend_req  = ((i / 3) % 2) == 0;
      outst_cnt = OW'((i / 5) % 4);
      lock_act  = (i % 11) < 3;
      step(1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule